// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block is the device end of a PS/2 link, as found in a keyboard. Bytes are pushed into a small pending queue through a valid/ready port. Each byte at the head of the queue is sent to the host as an 11-bit serial frame. The block produces both the clock and the data waveform itself and drives the two lines as open-drain outputs: a high output means "pull the line low". It reads the clock line back through a synchronizer, so it can see a host that holds the clock low to inhibit the link.

All timing comes from counting system-clock cycles. One timing unit is `TICK_CYC` cycles, nominally one microsecond. The clock low phase, the clock high phase, the data setup time before the first falling edge and the inhibit polling interval are each a number of such units.

While the link is inhibited, no frame starts and the byte stays queued. Inside a frame, the clock line is checked at a fixed polling interval. An inhibit found before the clock rises at the end of the parity bit abandons the frame, and the same byte is sent again later. An inhibit found after that rising edge lets the frame run to its end. A byte leaves the queue only when its stop bit has been sent.

Top module: `ps2_dev_tx`

## Requirements
- R1: Each frame is 11 bits, each presented on the data line before a falling clock edge. Bit 0 is a start bit of 0. Bits 1..8 are the data byte with the least significant bit first. Bit 9 is odd parity, so the count of ones over data and parity is odd. Bit 10 is a stop bit of 1.
- R2: Inside a frame, every clock low phase lasts exactly `LOW_TICKS*TICK_CYC` cycles, and every clock high phase between bits lasts exactly `HIGH_TICKS*TICK_CYC` cycles. Elaboration rejects a low phase outside 30..50 units, a high phase outside 30..40 units, or a period outside 60..80 units.
- R3: The data output changes only while the block releases the clock. It is constant across every clock low phase.
- R4: The start bit is placed on the data line exactly `SETUP_TICKS*TICK_CYC` cycles before the first falling clock edge of the frame.
- R5: While the clock line reads low and no frame is in progress, both outputs stay released and the queued byte is kept. It is sent once the clock line reads high again.
- R6: An inhibit detected before the rising clock edge that ends the parity bit's low phase abandons the frame. Both lines are released and no further clock edges are produced while the inhibit lasts. The same byte is later sent again as a full frame.
- R7: An inhibit detected after that parity rising edge does not stop the frame. The frame completes with its stop bit, the byte is removed and it is not sent again.
- R8: During a frame, the clock line is polled every `POLL_TICKS*TICK_CYC` cycles. A poll that falls in a clock low phase is resolved in the next released phase. A held inhibit is therefore acted on within one poll interval plus one clock period plus the synchronizer delay.
- R9: `push_ready` is the inverse of `fifo_full`. `fifo_full` rises when `FIFO_DEPTH` bytes are queued. A push while full is dropped. Bytes are sent in push order.
- R10: After reset, both line outputs are released, `fifo_full` is 0 and `push_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Byte offered to the pending queue |
| push_data | input | 8 | Byte to transmit |
| push_ready | output | 1 | Queue can accept a byte this cycle |
| fifo_full | output | 1 | Queue holds `FIFO_DEPTH` bytes |
| ps2_clk_in | input | 1 | Level read back from the clock line |
| ps2_clk_drive_low | output | 1 | 1 pulls the clock line low |
| ps2_dat_drive_low | output | 1 | 1 pulls the data line low |

## Verification
The hardest situation to reach is a host inhibit that lands at a chosen point of a running frame: once early enough to force an abandon, and once just after the parity rising edge so that the frame must complete. The stimulus counts the block's own falling clock edges. It asserts the host pull-down at the start of the released phase of bit 3 for the abandon case, and of bit 9 for the completion case. It holds the pull-down longer than a full poll interval plus one clock period. It then checks that the lines are quiet, or that the frame completed, and that the byte is resent or not resent as required.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_SETUP,
      TX_LOW,
      TX_HIGH
   } tx_state_e;

   localparam int unsigned FRAME_LEN = 11;

   // bit 0 start, 1..8 data LSB first, 9 odd parity, 10 stop
   function automatic logic [FRAME_LEN-1:0] pack_frame(input logic [7:0] d);
      return {1'b1, ~^d, d, 1'b0};
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out
);

   generate
      if (STAGES == 0) begin : g_direct
         assign line_out = line_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b1;
               else if (i == 0) chain[i] <= line_in;
               else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
         assign line_out = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ps2_interval_timer.sv
module ps2_interval_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (load) cnt <= load_val - W'(1);
      else if (cnt != '0) cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/ps2_tx_fifo.sv
module ps2_tx_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ready,
   output logic          full,
   output logic [DW-1:0] rd_data,
   output logic          nonempty,
   input  logic          rd_pop
);

   localparam int unsigned AW = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;
   logic          do_wr, do_rd;

   assign full     = (count == (AW+1)'(DEPTH));
   assign nonempty = (count != '0);
   assign wr_ready = !full;
   assign do_wr    = wr_valid && !full;
   assign do_rd    = rd_pop && nonempty;
   assign rd_data  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + AW'(1);
         if (do_rd) rd_ptr <= rd_ptr + AW'(1);
         if (do_wr && !do_rd) count <= count + (AW+1)'(1);
         else if (do_rd && !do_wr) count <= count - (AW+1)'(1);
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_valid && !rd_pop) |=> $stable(count));

   // R9
   pop_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> nonempty);

endmodule

// File: rtl/ps2_frame_engine.sv
module ps2_frame_engine
   import ps2_tx_pkg::*;
#(
   parameter int unsigned LOW_CYC     = 4100,
   parameter int unsigned HIGH_CYC    = 3500,
   parameter int unsigned SETUP_CYC   = 2000,
   parameter int unsigned POLL_CYC    = 6000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] head_data,
   input  logic       head_valid,
   output logic       pop,
   input  logic       clk_line,
   output logic       drv_clk_low,
   output logic       drv_dat_low
);

   localparam int unsigned PW = $clog2(max3(LOW_CYC, HIGH_CYC, SETUP_CYC) + 1);
   localparam int unsigned QW = $clog2(POLL_CYC + 1);
   localparam logic [3:0]  LAST_IDX   = 4'(FRAME_LEN - 1);
   localparam logic [3:0]  PARITY_IDX = 4'(FRAME_LEN - 2);
   localparam logic [2:0]  SETTLE_MAX = 3'(SYNC_STAGES + 1);

   tx_state_e           state;
   logic [3:0]          bit_idx;
   logic [2:0]          settle;
   logic                poll_pend;
   logic [FRAME_LEN-1:0] frame_bits;

   logic                ph_load, ph_exp;
   logic [PW-1:0]       ph_val;
   logic                pl_load, pl_exp;

   logic busy, start_frame, eligible, inhibit_seen, before_parity_edge, abort_evt;

   assign frame_bits  = pack_frame(head_data);
   assign busy        = (state != TX_IDLE);
   assign start_frame = (state == TX_IDLE) && head_valid && clk_line;
   assign eligible    = busy && !drv_clk_low && (settle == SETTLE_MAX);
   assign inhibit_seen = poll_pend && eligible && !clk_line;
   assign before_parity_edge = (state == TX_SETUP) ||
                               ((state == TX_HIGH) && (bit_idx < PARITY_IDX));
   assign abort_evt   = inhibit_seen && before_parity_edge;
   assign pop         = (state == TX_HIGH) && ph_exp && !abort_evt && (bit_idx == LAST_IDX);

   always_comb begin
      ph_load = 1'b0;
      ph_val  = '0;
      case (state)
         TX_IDLE:  if (start_frame) begin ph_load = 1'b1; ph_val = PW'(SETUP_CYC); end
         TX_SETUP: if (!abort_evt && ph_exp) begin ph_load = 1'b1; ph_val = PW'(LOW_CYC); end
         TX_LOW:   if (ph_exp) begin ph_load = 1'b1; ph_val = PW'(HIGH_CYC); end
         TX_HIGH:  if (!abort_evt && ph_exp && (bit_idx != LAST_IDX)) begin
                      ph_load = 1'b1;
                      ph_val  = PW'(LOW_CYC);
                   end
         default: ;
      endcase
   end

   assign pl_load = start_frame || (busy && pl_exp);

   ps2_interval_timer #(.W(PW)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_exp)
   );

   ps2_interval_timer #(.W(QW)) u_poll (
      .clk(clk), .rst_n(rst_n), .load(pl_load), .load_val(QW'(POLL_CYC)), .expired(pl_exp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         settle    <= '0;
         poll_pend <= 1'b0;
      end else begin
         if (drv_clk_low) settle <= '0;
         else if (settle != SETTLE_MAX) settle <= settle + 3'd1;

         if (start_frame) poll_pend <= 1'b0;
         else if (busy && pl_exp) poll_pend <= 1'b1;
         else if (eligible) poll_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= TX_IDLE;
         bit_idx     <= '0;
         drv_clk_low <= 1'b0;
         drv_dat_low <= 1'b0;
      end else begin
         case (state)
            TX_IDLE: begin
               if (start_frame) begin
                  state       <= TX_SETUP;
                  bit_idx     <= '0;
                  drv_dat_low <= !frame_bits[0];
               end
            end
            TX_SETUP: begin
               if (abort_evt) begin
                  state       <= TX_IDLE;
                  drv_dat_low <= 1'b0;
               end else if (ph_exp) begin
                  state       <= TX_LOW;
                  drv_clk_low <= 1'b1;
               end
            end
            TX_LOW: begin
               if (ph_exp) begin
                  state       <= TX_HIGH;
                  drv_clk_low <= 1'b0;
                  if (bit_idx != LAST_IDX) drv_dat_low <= !frame_bits[bit_idx + 4'd1];
                  else drv_dat_low <= 1'b0;
               end
            end
            TX_HIGH: begin
               if (abort_evt) begin
                  state       <= TX_IDLE;
                  drv_dat_low <= 1'b0;
               end else if (ph_exp) begin
                  if (bit_idx == LAST_IDX) begin
                     state       <= TX_IDLE;
                     drv_dat_low <= 1'b0;
                  end else begin
                     state       <= TX_LOW;
                     bit_idx     <= bit_idx + 4'd1;
                     drv_clk_low <= 1'b1;
                  end
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   // R1
   bit_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx <= LAST_IDX);

   // R3
   data_moves_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drv_dat_low) |-> !drv_clk_low);

   // R5
   inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_IDLE && !clk_line) |=> (!drv_clk_low && !drv_dat_low));

   // R6
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |=> (state == TX_IDLE && !drv_clk_low && !drv_dat_low));

   // R7
   pop_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (state == TX_IDLE && !drv_clk_low));

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
   parameter int unsigned TICK_CYC    = 100,
   parameter int unsigned LOW_TICKS   = 41,
   parameter int unsigned HIGH_TICKS  = 35,
   parameter int unsigned SETUP_TICKS = 20,
   parameter int unsigned POLL_TICKS  = 60,
   parameter int unsigned FIFO_DEPTH  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push_valid,
   input  logic [7:0] push_data,
   output logic       push_ready,
   output logic       fifo_full,
   input  logic       ps2_clk_in,
   output logic       ps2_clk_drive_low,
   output logic       ps2_dat_drive_low
);

   localparam int unsigned LOW_CYC   = LOW_TICKS * TICK_CYC;
   localparam int unsigned HIGH_CYC  = HIGH_TICKS * TICK_CYC;
   localparam int unsigned SETUP_CYC = SETUP_TICKS * TICK_CYC;
   localparam int unsigned POLL_CYC  = POLL_TICKS * TICK_CYC;

   generate
      if (TICK_CYC < 1) begin : g_bad_tick
         $error("TICK_CYC must be at least 1");
      end
      if (LOW_TICKS < 30 || LOW_TICKS > 50) begin : g_bad_low
         $error("LOW_TICKS outside 30..50");
      end
      if (HIGH_TICKS < 30 || HIGH_TICKS > 40) begin : g_bad_high
         $error("HIGH_TICKS outside 30..40");
      end
      if (LOW_TICKS + HIGH_TICKS < 60 || LOW_TICKS + HIGH_TICKS > 80) begin : g_bad_period
         $error("clock period outside 60..80");
      end
      if (SETUP_TICKS < 1 || POLL_TICKS < 1) begin : g_bad_interval
         $error("SETUP_TICKS and POLL_TICKS must be nonzero");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two, at least 2");
      end
      if (SYNC_STAGES > 5) begin : g_bad_sync
         $error("SYNC_STAGES at most 5");
      end
   endgenerate

   logic       clk_line;
   logic [7:0] head_data;
   logic       head_valid;
   logic       pop;

   ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(ps2_clk_in), .line_out(clk_line)
   );

   ps2_tx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(push_valid), .wr_data(push_data), .wr_ready(push_ready), .full(fifo_full),
      .rd_data(head_data), .nonempty(head_valid), .rd_pop(pop)
   );

   ps2_frame_engine #(
      .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .SETUP_CYC(SETUP_CYC),
      .POLL_CYC(POLL_CYC), .SYNC_STAGES(SYNC_STAGES)
   ) u_engine (
      .clk(clk), .rst_n(rst_n),
      .head_data(head_data), .head_valid(head_valid), .pop(pop),
      .clk_line(clk_line),
      .drv_clk_low(ps2_clk_drive_low), .drv_dat_low(ps2_dat_drive_low)
   );

   // R9
   ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_ready != fifo_full);

endmodule

// File: tb/ps2_dev_tx_test.sv
module ps2_dev_tx_test;

   localparam int TICK = 2;
   localparam int LOW_CYC = 41 * TICK;
   localparam int HIGH_CYC = 35 * TICK;
   localparam int SETUP_CYC = 20 * TICK;
   localparam int POLL_CYC = 60 * TICK;
   localparam int DEPTH = 4;

   // {odd parity bit, data}
   localparam logic [8:0] VEC [8] = '{
      {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h01}, {1'b1, 8'hA5},
      {1'b0, 8'h80}, {1'b1, 8'h3C}, {1'b1, 8'h7E}, {1'b0, 8'h13}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic push_valid = 1'b0;
   logic [7:0] push_data = 8'h00;
   logic push_ready, fifo_full, dut_clk_low, dut_dat_low;
   logic host_clk_low = 1'b0;
   logic line_clk;
   assign line_clk = !(dut_clk_low || host_clk_low);

   ps2_dev_tx #(.TICK_CYC(TICK), .FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .push_ready(push_ready), .fifo_full(fifo_full), .ps2_clk_in(line_clk),
      .ps2_clk_drive_low(dut_clk_low), .ps2_dat_drive_low(dut_dat_low)
   );

   int errors = 0, checks = 0, cyc = 0;
   bit done = 1'b0;

   // monitor state
   int falls = 0, bitcnt = 0, rx_cnt = 0, abort_cnt = 0;
   int rel_run = 0, low_run = 0, setup_run = 0, setup_last = 0, stab_bad = 0;
   int low_min = 1000000, low_max = 0, high_min = 1000000, high_max = 0;
   bit meas_en = 1'b0;
   logic prev_clk = 1'b0, prev_dat = 1'b0;
   logic [10:0] cur_bits = '0;
   logic [10:0] rx_frames [32];

   always @(negedge clk) begin
      if (rst_n) begin
         if (dut_clk_low && !prev_clk) begin
            if (bitcnt == 0) setup_last = setup_run;
            else if (meas_en) begin
               if (rel_run < high_min) high_min = rel_run;
               if (rel_run > high_max) high_max = rel_run;
            end
            cur_bits[bitcnt] = !dut_dat_low;
            bitcnt++;
            falls++;
            if (bitcnt == 11) begin
               rx_frames[rx_cnt % 32] = cur_bits;
               rx_cnt++;
               bitcnt = 0;
            end
         end
         if (!dut_clk_low && prev_clk && meas_en) begin
            if (low_run < low_min) low_min = low_run;
            if (low_run > low_max) low_max = low_run;
         end
         if (dut_clk_low && prev_clk && (dut_dat_low != prev_dat)) stab_bad++;
         if (dut_clk_low) begin low_run++; rel_run = 0; end
         else begin rel_run++; low_run = 0; end
         if (dut_dat_low && !dut_clk_low) setup_run++;
         else setup_run = 0;
         if (!dut_clk_low && rel_run > HIGH_CYC + 4 && bitcnt != 0) begin
            abort_cnt++;
            bitcnt = 0;
         end
      end
      prev_clk = dut_clk_low;
      prev_dat = dut_dat_low;
   end

   function automatic logic [10:0] mk_frame(input logic par, input logic [7:0] d);
      return {1'b1, par, d, 1'b0};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_byte(input logic [7:0] d);
      int t = 0;
      @(negedge clk);
      while (!push_ready && t < 50000) begin @(negedge clk); t++; end
      push_valid = 1'b1;
      push_data = d;
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic push_force(input logic [7:0] d);
      @(negedge clk);
      push_valid = 1'b1;
      push_data = d;
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic wait_rx(input int n);
      int t = 0;
      while (rx_cnt < n && t < 20000) begin @(negedge clk); t++; end
   endtask

   task automatic wait_falls_high(input int n);
      int t = 0;
      while (!(falls == n && !dut_clk_low) && t < 20000) begin @(negedge clk); t++; end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=finished", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int base, f0, f1, a0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      chk(!dut_clk_low && !dut_dat_low, "R10 lines", {dut_clk_low, dut_dat_low}, 0);
      chk(push_ready && !fifo_full, "R10 queue", {push_ready, fifo_full}, 2);

      // R1 table walk
      meas_en = 1'b1;
      for (int i = 0; i < 8; i++) begin
         push_byte(VEC[i][7:0]);
         wait_rx(i + 1);
         chk(rx_frames[i] == mk_frame(VEC[i][8], VEC[i][7:0]), "R1 frame",
             rx_frames[i], mk_frame(VEC[i][8], VEC[i][7:0]));
      end
      meas_en = 1'b0;
      // R2
      chk(low_min == LOW_CYC && low_max == LOW_CYC, "R2 low phase", low_max, LOW_CYC);
      chk(high_min == HIGH_CYC && high_max == HIGH_CYC, "R2 high phase", high_max, HIGH_CYC);
      // R3
      chk(stab_bad == 0, "R3 data stable in low", stab_bad, 0);
      // R4
      chk(setup_last == SETUP_CYC, "R4 setup", setup_last, SETUP_CYC);

      // R5 and R9: queue fills while inhibited
      base = rx_cnt;
      f0 = falls;
      host_clk_low = 1'b1;
      repeat (10) @(negedge clk);
      push_byte(8'h11);
      push_byte(8'h22);
      push_byte(8'h33);
      push_byte(8'h44);
      @(negedge clk);
      chk(fifo_full && !push_ready, "R9 full flag", {fifo_full, push_ready}, 2);
      push_force(8'h55);
      repeat (2000) @(negedge clk);
      chk(rx_cnt == base && falls == f0, "R5 no frame while inhibited", falls - f0, 0);
      chk(!dut_dat_low && !dut_clk_low, "R5 lines released", {dut_clk_low, dut_dat_low}, 0);
      host_clk_low = 1'b0;
      wait_rx(base + 4);
      chk(rx_frames[base % 32] == mk_frame(1'b1, 8'h11), "R5 R9 order 0",
          rx_frames[base % 32], mk_frame(1'b1, 8'h11));
      chk(rx_frames[(base + 1) % 32] == mk_frame(1'b1, 8'h22), "R9 order 1",
          rx_frames[(base + 1) % 32], mk_frame(1'b1, 8'h22));
      chk(rx_frames[(base + 2) % 32] == mk_frame(1'b1, 8'h33), "R9 order 2",
          rx_frames[(base + 2) % 32], mk_frame(1'b1, 8'h33));
      chk(rx_frames[(base + 3) % 32] == mk_frame(1'b1, 8'h44), "R9 order 3",
          rx_frames[(base + 3) % 32], mk_frame(1'b1, 8'h44));
      repeat (2500) @(negedge clk);
      chk(rx_cnt == base + 4, "R9 push while full dropped", rx_cnt - base, 4);

      // R6 and R8: early inhibit abandons the frame
      base = rx_cnt;
      a0 = abort_cnt;
      f0 = falls;
      push_byte(8'h5A);
      wait_falls_high(f0 + 4);
      host_clk_low = 1'b1;
      repeat (POLL_CYC + LOW_CYC + HIGH_CYC + 8) @(negedge clk);
      chk(!dut_clk_low && !dut_dat_low, "R8 inhibit acted on in time",
          {dut_clk_low, dut_dat_low}, 0);
      f1 = falls;
      repeat (400) @(negedge clk);
      chk(falls == f1, "R6 no edges while inhibited", falls - f1, 0);
      chk(abort_cnt == a0 + 1 && rx_cnt == base, "R6 frame abandoned", abort_cnt - a0, 1);
      host_clk_low = 1'b0;
      wait_rx(base + 1);
      chk(rx_frames[base % 32] == mk_frame(1'b1, 8'h5A), "R6 byte resent",
          rx_frames[base % 32], mk_frame(1'b1, 8'h5A));

      // R7: inhibit after the parity rising edge
      base = rx_cnt;
      a0 = abort_cnt;
      f0 = falls;
      push_byte(8'hC3);
      wait_falls_high(f0 + 10);
      host_clk_low = 1'b1;
      wait_rx(base + 1);
      chk(rx_frames[base % 32] == mk_frame(1'b1, 8'hC3), "R7 frame completed",
          rx_frames[base % 32], mk_frame(1'b1, 8'hC3));
      repeat (300) @(negedge clk);
      host_clk_low = 1'b0;
      repeat (2500) @(negedge clk);
      chk(rx_cnt == base + 1, "R7 not resent", rx_cnt - base, 1);
      chk(abort_cnt == a0, "R7 no abandon", abort_cnt - a0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule